// File: doc/BRIEF.md
# Event-Counting Performance Monitor

This block counts processor activity for profiling. It holds one free-running cycle counter and four event counters, each 32 bits wide. Every event counter watches one line of a 128-bit vector of event pulses, picked by a 7-bit event number, and advances on each clock in which that line is high. The cycle counter advances on every clock, or once every 64 clocks when its slow mode is selected. Software presets a counter to the negative of a sampling period. The counter then wraps after that many events, sets a sticky overflow flag and can raise the single interrupt line.

Software uses a single-cycle register port: a write takes effect at the clock edge where `reg_we` is high, and `reg_rdata` shows the addressed register combinationally. The register words are: 0x0 control, 0x1 enable-set, 0x2 enable-clear, 0x3 interrupt-enable-set, 0x4 overflow flags, 0x5 counter select, 0x6 event number of the selected counter, 0x7 count of the selected counter, 0x8 cycle count. Unmapped words read 0. The enable, interrupt-enable and flag words share one bit layout: bits 3:0 belong to event counters 3..0 and bit 31 to the cycle counter. All other bits read 0 and are ignored on write.

Top module: `perfmon_unit`

## Requirements
- R1: After reset every register reads 0, all counters hold 0 and `irq_o` is low.
- R2: Control (0x0) bit 0 is the global run enable, bit 3 selects the slow cycle mode, bits 4 and 5 are stored, and bits above 5 are dropped. Bit 1 zeroes all event counters and bit 2 zeroes the cycle counter and its prescaler. Bits 1 and 2 act only in the cycle of the write and always read back 0.
- R3: Writing 1s to enable-set (0x1) enables those counters, and writing 1s to enable-clear (0x2) disables them. Zero bits change nothing. Both words read back the current enable state in the shared layout.
- R4: An event counter advances by one in a clock cycle only when the global run bit, its own enable bit and the event line picked by its event number are all high. Otherwise it holds.
- R5: The cycle counter advances every clock while the run bit and its enable (bit 31) are set. In slow mode it advances once every 64 such clocks, counted from the last cycle-counter reset.
- R6: A counter that advances from 0xFFFFFFFF reaches 0, sets its overflow flag and keeps counting from 0.
- R7: The flag word (0x4) reads the pending overflow flags, and writing a 1 to a bit clears that flag.
- R8: Writing 1s to interrupt-enable-set (0x3) arms those counters. The word reads back the armed set. `irq_o` is high exactly while some flag is set whose interrupt is armed.
- R9: The select word (0x5) keeps 5 bits. Event number (0x6, 7 bits) and count (0x7) reach the event counter named by the select value. With a select value above 3 they read 0 and writes to them are ignored.
- R10: A software write to a count in the same cycle as an increment wins: the counter takes the written value and no overflow is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 4 | Register word address |
| reg_we | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the addressed word |
| event_i | input | 128 | Event pulse vector, one line per event number |
| irq_o | output | 1 | Overflow interrupt |

## Verification
On every cycle, the embedded assertions check these local rules: a wrapping counter lands on 0 and its flag is set on the next cycle; an idle counter holds its value; a slow-mode cycle counter moves only on the 64th tick; software writes beat increments; and flags change only through a wrap or a clearing write. Exact count values, the bit layout of the shared words, the one-shot behaviour of the reset bits, masking of out-of-range selects and the interrupt/flag interplay show up only in the bench's scenarios, which read the words back through the register port.

// File: rtl/perfmon_pkg.sv
package perfmon_pkg;

  localparam int PM_NUM_EV = 4;
  localparam int PM_WORD_W = 32;
  localparam int PM_MSK_W  = PM_NUM_EV + 1;

  localparam logic [3:0] PM_A_CTRL   = 4'h0;
  localparam logic [3:0] PM_A_ENSET  = 4'h1;
  localparam logic [3:0] PM_A_ENCLR  = 4'h2;
  localparam logic [3:0] PM_A_IESET  = 4'h3;
  localparam logic [3:0] PM_A_FLAGS  = 4'h4;
  localparam logic [3:0] PM_A_SEL    = 4'h5;
  localparam logic [3:0] PM_A_EVNUM  = 4'h6;
  localparam logic [3:0] PM_A_EVCNT  = 4'h7;
  localparam logic [3:0] PM_A_CYCCNT = 4'h8;

  // internal mask: bits NUM_EV-1:0 event counters, bit NUM_EV cycle counter
  function automatic logic [PM_WORD_W-1:0] pm_spread(input logic [PM_MSK_W-1:0] m);
    logic [PM_WORD_W-1:0] w;
    w = '0;
    w[PM_NUM_EV-1:0] = m[PM_NUM_EV-1:0];
    w[PM_WORD_W-1]   = m[PM_NUM_EV];
    return w;
  endfunction

  function automatic logic [PM_MSK_W-1:0] pm_gather(input logic [PM_WORD_W-1:0] w);
    return {w[PM_WORD_W-1], w[PM_NUM_EV-1:0]};
  endfunction

endpackage

// File: rtl/perfmon_evcnt.sv
module perfmon_evcnt #(
  parameter int CNT_W = 32,
  parameter int NUM_W = 7,
  localparam int EV_W = 1 << NUM_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [EV_W-1:0]  ev_i,
  input  logic             clr_i,
  input  logic             num_we_i,
  input  logic             cnt_we_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [NUM_W-1:0] num_o,
  output logic             wrap_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [NUM_W-1:0] num_q;
  logic             hit;
  logic             sw_touch;

  assign hit      = run_i & ev_i[num_q];
  assign sw_touch = clr_i | cnt_we_i;
  assign wrap_o   = hit & ~sw_touch & (&cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      num_q <= '0;
    end else begin
      if (num_we_i) num_q <= wdata_i[NUM_W-1:0];
      if (clr_i)         cnt_q <= '0;
      else if (cnt_we_i) cnt_q <= wdata_i;
      else if (hit)      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o = cnt_q;
  assign num_o = num_q;

  assert_ev_wrap_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_o |=> (cnt_q == '0));

  assert_ev_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !clr_i && !cnt_we_i) |=> $stable(cnt_q));

  assert_ev_write_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_we_i && !clr_i) |=> (cnt_q == $past(wdata_i)));

endmodule

// File: rtl/perfmon_cyccnt.sv
module perfmon_cyccnt #(
  parameter int CNT_W = 32,
  parameter int PRE_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             slow_i,
  input  logic             clr_i,
  input  logic             cnt_we_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [PRE_W-1:0] pre_q;
  logic             tick;

  assign tick   = run_i & (~slow_i | (&pre_q));
  assign wrap_o = tick & ~clr_i & ~cnt_we_i & (&cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      pre_q <= '0;
    end else begin
      if (clr_i)                pre_q <= '0;
      else if (run_i && slow_i) pre_q <= pre_q + 1'b1;
      if (clr_i)         cnt_q <= '0;
      else if (cnt_we_i) cnt_q <= wdata_i;
      else if (tick)     cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o = cnt_q;

  assert_cyc_slow_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && slow_i && !(&pre_q) && !clr_i && !cnt_we_i) |=> $stable(cnt_q));

  assert_cyc_wrap_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_o |=> (cnt_q == '0));

endmodule

// File: rtl/perfmon_unit.sv
module perfmon_unit
  import perfmon_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int NUM_W  = 7,
  parameter int SEL_W  = 5,
  parameter int PRE_W  = 6,
  parameter int ADDR_W = 4,
  localparam int EV_W  = 1 << NUM_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic                 reg_we,
  input  logic [PM_WORD_W-1:0] reg_wdata,
  output logic [PM_WORD_W-1:0] reg_rdata,
  input  logic [EV_W-1:0]      event_i,
  output logic                 irq_o
);

  localparam int CYC = PM_NUM_EV;

  logic [5:0]          ctrl_q;
  logic [PM_MSK_W-1:0] en_q, ie_q, flag_q;
  logic [SEL_W-1:0]    sel_q;
  logic [PM_MSK_W-1:0] wrap_vec;
  logic                sel_ok;
  logic                run_all, slow_mode, ev_clr, cyc_clr;
  logic                wr_ctrl, wr_enset, wr_enclr, wr_ieset, wr_flags, wr_sel;
  logic                wr_num, wr_cnt, wr_cyc;
  logic [PM_MSK_W-1:0] wmask;

  logic [CNT_W-1:0] ev_cnt [PM_NUM_EV];
  logic [NUM_W-1:0] ev_num [PM_NUM_EV];
  logic [CNT_W-1:0] cyc_cnt;

  assign wr_ctrl  = reg_we && (reg_addr == PM_A_CTRL);
  assign wr_enset = reg_we && (reg_addr == PM_A_ENSET);
  assign wr_enclr = reg_we && (reg_addr == PM_A_ENCLR);
  assign wr_ieset = reg_we && (reg_addr == PM_A_IESET);
  assign wr_flags = reg_we && (reg_addr == PM_A_FLAGS);
  assign wr_sel   = reg_we && (reg_addr == PM_A_SEL);
  assign wr_num   = reg_we && (reg_addr == PM_A_EVNUM);
  assign wr_cnt   = reg_we && (reg_addr == PM_A_EVCNT);
  assign wr_cyc   = reg_we && (reg_addr == PM_A_CYCCNT);

  assign wmask     = pm_gather(reg_wdata);
  assign sel_ok    = (sel_q < SEL_W'(PM_NUM_EV));
  assign run_all   = ctrl_q[0];
  assign slow_mode = ctrl_q[3];
  assign ev_clr    = wr_ctrl & reg_wdata[1];
  assign cyc_clr   = wr_ctrl & reg_wdata[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      en_q   <= '0;
      ie_q   <= '0;
      flag_q <= '0;
      sel_q  <= '0;
    end else begin
      if (wr_ctrl)  ctrl_q <= {reg_wdata[5:3], 2'b00, reg_wdata[0]};
      if (wr_enset) en_q   <= en_q | wmask;
      else if (wr_enclr) en_q <= en_q & ~wmask;
      if (wr_ieset) ie_q   <= ie_q | wmask;
      if (wr_sel)   sel_q  <= reg_wdata[SEL_W-1:0];
      flag_q <= (flag_q & ~(wr_flags ? wmask : '0)) | wrap_vec;
    end
  end

  for (genvar g = 0; g < PM_NUM_EV; g++) begin : g_ev
    logic hit_sel;
    assign hit_sel = sel_ok && (sel_q[1:0] == 2'(g));
    perfmon_evcnt #(.CNT_W(CNT_W), .NUM_W(NUM_W)) ev_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .run_i    (run_all & en_q[g]),
      .ev_i     (event_i),
      .clr_i    (ev_clr),
      .num_we_i (wr_num & hit_sel),
      .cnt_we_i (wr_cnt & hit_sel),
      .wdata_i  (reg_wdata[CNT_W-1:0]),
      .cnt_o    (ev_cnt[g]),
      .num_o    (ev_num[g]),
      .wrap_o   (wrap_vec[g])
    );
  end

  perfmon_cyccnt #(.CNT_W(CNT_W), .PRE_W(PRE_W)) cyc_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_i    (run_all & en_q[CYC]),
    .slow_i   (slow_mode),
    .clr_i    (cyc_clr),
    .cnt_we_i (wr_cyc),
    .wdata_i  (reg_wdata[CNT_W-1:0]),
    .cnt_o    (cyc_cnt),
    .wrap_o   (wrap_vec[CYC])
  );

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      PM_A_CTRL:   reg_rdata[5:0] = ctrl_q;
      PM_A_ENSET,
      PM_A_ENCLR:  reg_rdata = pm_spread(en_q);
      PM_A_IESET:  reg_rdata = pm_spread(ie_q);
      PM_A_FLAGS:  reg_rdata = pm_spread(flag_q);
      PM_A_SEL:    reg_rdata[SEL_W-1:0] = sel_q;
      PM_A_EVNUM:  if (sel_ok) reg_rdata[NUM_W-1:0] = ev_num[sel_q[1:0]];
      PM_A_EVCNT:  if (sel_ok) reg_rdata[CNT_W-1:0] = ev_cnt[sel_q[1:0]];
      PM_A_CYCCNT: reg_rdata[CNT_W-1:0] = cyc_cnt;
      default:     reg_rdata = '0;
    endcase
  end

  assign irq_o = |(flag_q & ie_q);

  assert_flag_after_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_vec != '0) |=> ((flag_q & $past(wrap_vec)) == $past(wrap_vec)));

  assert_flags_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_vec == '0 && !wr_flags) |=> $stable(flag_q));

  assert_oneshot_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |-> (ctrl_q[2:1] == 2'b00));

endmodule

// File: tb/perfmon_unit_tb_top.sv
module perfmon_unit_tb_top;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [3:0]   reg_addr = '0;
  logic         reg_we = 1'b0;
  logic [31:0]  reg_wdata = '0;
  logic [31:0]  reg_rdata;
  logic [127:0] event_i = '0;
  logic         irq_o;

  int checks = 0;
  int errors = 0;
  logic mon_req = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  perfmon_unit dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .event_i(event_i), .irq_o(irq_o)
  );

  // monitor: pops expected read data and compares mid-cycle
  always @(negedge clk) begin
    if (mon_req && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (reg_rdata !== e) begin
        errors++;
        $display("FAIL %s: got %h expected %h", t, reg_rdata, e);
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(posedge clk); #1;
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] e, input string t);
    reg_addr = a; reg_we = 1'b0;
    exp_q.push_back(e); tag_q.push_back(t);
    mon_req = 1'b1;
    @(posedge clk); #1;
    mon_req = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    checks++;
    if (irq_o !== e) begin
      errors++;
      $display("FAIL %s: irq got %b expected %b", t, irq_o, e);
    end
  endtask

  task automatic run_for(input int n, input logic [31:0] c);
    wr(4'h0, c);
    repeat (n - 1) begin @(posedge clk); #1; end
    wr(4'h0, 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: run did not complete, got timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk); #1;
    rst_n = 1'b1;
    @(posedge clk); #1;

    // R1 reset state
    rd(4'h0, 32'h0, "R1 ctrl");
    rd(4'h1, 32'h0, "R1 enables");
    rd(4'h4, 32'h0, "R1 flags");
    rd(4'h8, 32'h0, "R1 cycle count");
    chk_irq(1'b0, "R1 irq");

    // R2 control write mask
    wr(4'h0, 32'hFFFF_FF3F);
    rd(4'h0, 32'h39, "R2 ctrl readback");
    wr(4'h0, 32'h0);

    // R3 enable set/clear
    wr(4'h1, 32'h8000_0005);
    rd(4'h1, 32'h8000_0005, "R3 enset read");
    rd(4'h2, 32'h8000_0005, "R3 enclr read");
    wr(4'h2, 32'h1);
    rd(4'h1, 32'h8000_0004, "R3 clear one");
    wr(4'h1, 32'h0);
    rd(4'h2, 32'h8000_0004, "R3 zero write no change");
    wr(4'h1, 32'hFFFF_FFFF);
    rd(4'h1, 32'h8000_000F, "R3 mask");

    // R9 select and event number mask
    wr(4'h5, 32'hFF);
    rd(4'h5, 32'h1F, "R9 select width");
    wr(4'h5, 32'h1); wr(4'h6, 32'hFFF);
    rd(4'h6, 32'h7F, "R9 event number width");

    // R4 counting conditions
    wr(4'h5, 32'h0); wr(4'h6, 32'd5);
    wr(4'h5, 32'h1); wr(4'h6, 32'd6);
    wr(4'h5, 32'h2); wr(4'h6, 32'd127);
    wr(4'h5, 32'h3); wr(4'h6, 32'd5);
    wr(4'h2, 32'h8);
    event_i = '0; event_i[5] = 1'b1;
    wr(4'h0, 32'h6);
    rd(4'h0, 32'h0, "R2 reset bits one-shot");
    run_for(10, 32'h1);
    wr(4'h5, 32'h0); rd(4'h7, 32'd10, "R4 selected event high");
    wr(4'h5, 32'h1); rd(4'h7, 32'd0, "R4 selected event low");
    wr(4'h5, 32'h2); rd(4'h7, 32'd0, "R4 event 127 low");
    wr(4'h5, 32'h3); rd(4'h7, 32'd0, "R4 own enable off");
    rd(4'h8, 32'd10, "R5 cycle count every clock");

    // R5 slow mode
    wr(4'h0, 32'h4);
    rd(4'h8, 32'd0, "R2 cycle reset");
    run_for(130, 32'h9);
    rd(4'h8, 32'd2, "R5 divide by 64");
    wr(4'h5, 32'h0); rd(4'h7, 32'd140, "R4 continued count");

    // R6 / R7 / R8 overflow
    wr(4'h7, 32'hFFFF_FFFE);
    wr(4'h8, 32'hFFFF_FFFF);
    wr(4'h3, 32'h1);
    run_for(3, 32'h1);
    rd(4'h7, 32'd1, "R6 event wrap continues");
    rd(4'h8, 32'd2, "R6 cycle wrap continues");
    rd(4'h4, 32'h8000_0001, "R6 flags set");
    chk_irq(1'b1, "R8 irq armed flag");
    wr(4'h4, 32'h1);
    rd(4'h4, 32'h8000_0000, "R7 w1c");
    chk_irq(1'b0, "R8 unarmed flag");
    wr(4'h3, 32'h8000_0000);
    rd(4'h3, 32'h8000_0001, "R8 ie readback");
    chk_irq(1'b1, "R8 cycle armed");
    wr(4'h4, 32'h8000_0000);
    rd(4'h4, 32'h0, "R7 cleared");
    chk_irq(1'b0, "R8 irq drops");

    // R9 out-of-range select
    wr(4'h5, 32'h7);
    wr(4'h7, 32'h1234);
    wr(4'h6, 32'h22);
    rd(4'h7, 32'h0, "R9 count reads 0");
    rd(4'h6, 32'h0, "R9 number reads 0");
    wr(4'h5, 32'h0); rd(4'h7, 32'd1, "R9 write ignored c0");
    rd(4'h6, 32'd5, "R9 number ignored c0");
    wr(4'h5, 32'h3); rd(4'h7, 32'd0, "R9 write ignored c3");

    // R10 write over increment
    wr(4'h5, 32'h0);
    wr(4'h0, 32'h1); wr(4'h7, 32'h100); wr(4'h0, 32'h0);
    rd(4'h7, 32'h101, "R10 write wins");
    wr(4'h7, 32'hFFFF_FFFF);
    wr(4'h0, 32'h1); wr(4'h7, 32'd5); wr(4'h0, 32'h0);
    rd(4'h7, 32'd6, "R10 write beats wrap");
    rd(4'h4, 32'h0, "R10 no flag");
    rd(4'h8, 32'd6, "R5 cycle running");

    // R2 separate reset commands
    wr(4'h0, 32'h2);
    rd(4'h7, 32'd0, "R2 event reset");
    rd(4'h8, 32'd6, "R2 cycle untouched");
    wr(4'h0, 32'h4);
    rd(4'h8, 32'd0, "R2 cycle reset cmd");
    rd(4'h0, 32'h0, "R2 ctrl after cmds");

    @(posedge clk); #1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule